// File: doc/BRIEF.md
# Partial-Sum Reconstruction Unit

This unit sits after the column readout of a compute array whose columns have been placed in key-scrambled order. Each logical word is stored in two columns. The weight key says which columns hold the first half of a word (key bit 1) and which hold the second half (key bit 0). Within each group the word order is kept. Using the same key, the unit gathers the two groups back into word order without adding a clock cycle. It then merges each pair of columns into one signed word, either as a shifted nibble pair or as a positive/negative difference.

Inputs arrive bit-serially in two compute cycles, one for the upper 4-bit part and one for the lower 4-bit part. A separate input key decides which of the two cycles carried the upper part. Once both cycles have been seen, the unit weights the upper-part words by 16, adds the lower-part words, and registers the final sums. This step adds exactly one clock cycle, and a one-cycle done flag marks it. The two keys are independent and act together. If the keys do not match the ones used for scrambling, the output is garbage.

Top module: `psum_recon`

## Requirements
- R1: For word k (0-based), the "one" half is the column holding the (k+1)-th set bit of `wkey_i`, and the "zero" half is the column holding the (k+1)-th clear bit. Columns are counted from index 0. Column j sits in bits `col_sum_i[j*PSUM_W +: PSUM_W]` as signed two's complement. `wkey_i` holds exactly N_WORDS ones.
- R2: With `mode_i`=0 (nibble), word k is one*16 + zero, signed.
- R3: With `mode_i`=1 (differential), word k is one − zero, signed.
- R4: `word_o` is combinational. It follows `col_sum_i`, `wkey_i` and `mode_i` in the same cycle, with no register in between. Word k sits in `word_o[k*(PSUM_W+5) +: PSUM_W+5]`.
- R5: Two cycles with `valid_i` high make one input. Any number of idle cycles may fall between them. `ikey_i` is sampled on the first of the two: 1 means the first cycle carried the upper part, 0 means the second did. The final word k is upper*16 + lower. It sits in `result_o[k*(PSUM_W+10) +: PSUM_W+10]`.
- R6: `result_o` updates on the clock edge that ends the second valid cycle, and `done_o` is high for exactly that one following cycle.
- R7: Between completions, `result_o` holds its value and `done_o` stays low.
- R8: After reset, `done_o` is 0, `result_o` is 0 and the next valid cycle is taken as the first half.
- R9: If words are placed with one weight key and reconstructed with a different balanced key, `word_o` differs from the intended words. With the same key, it equals them.
- R10: Full-scale column sums (−2^(PSUM_W−1) and 2^(PSUM_W−1)−1) give exact results in both modes and in the serial combine, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Column sums present this cycle |
| mode_i | input | 1 | 0 nibble merge, 1 differential merge |
| wkey_i | input | 2*N_WORDS | Weight key, one bit per column |
| ikey_i | input | 1 | Input key: 1 = upper part comes first |
| col_sum_i | input | 2*N_WORDS*PSUM_W | Signed column sums, scrambled order |
| word_o | output | N_WORDS*(PSUM_W+5) | Per-cycle reconstructed words |
| result_o | output | N_WORDS*(PSUM_W+10) | Final serial-combined sums |
| done_o | output | 1 | One-cycle flag with fresh result_o |

## Verification
The gather is tried with several keys:
- A key with all ones in the low columns keeps the column order, so it separates the gather from the merge arithmetic.
- An alternating key and an irregular key expose rank-counting errors and swapped halves.

Differential and nibble modes run on the same data, which shows whether mode selection is wired correctly. Full-scale negative and positive sums catch sign-extension and width faults. Serial pairs are run with both input-key values and with idle gaps between halves, which tells apart the wrong half being weighted, a lost phase and an early or late done. A reconstruction under a foreign key must differ from the intended words.

// File: rtl/psum_recon_pkg.sv
package psum_recon_pkg;
  typedef enum logic {
    MERGE_NIBBLE = 1'b0,
    MERGE_DIFF   = 1'b1
  } merge_mode_e;

  localparam int unsigned NIB_SHIFT = 4;
  localparam int unsigned GROW_W    = 5;
endpackage

// File: rtl/psum_recon_gather.sv
module psum_recon_gather #(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned PSUM_W  = 10
) (
  input  logic [2*N_WORDS-1:0]        key_i,
  input  logic [2*N_WORDS*PSUM_W-1:0] col_i,
  output logic [N_WORDS*PSUM_W-1:0]   one_o,
  output logic [N_WORDS*PSUM_W-1:0]   zero_o
);
  localparam int unsigned COLS  = 2 * N_WORDS;
  localparam int unsigned CNT_W = $clog2(COLS + 1);

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic [PSUM_W-1:0] one_v, zero_v;
    logic [CNT_W-1:0]  n_one, n_zero;

    // k-th set column feeds one half, k-th clear column the other
    always_comb begin
      one_v  = '0;
      zero_v = '0;
      n_one  = '0;
      n_zero = '0;
      for (int j = 0; j < COLS; j++) begin
        if (key_i[j]) begin
          if (n_one == CNT_W'(k)) one_v = col_i[j*PSUM_W +: PSUM_W];
          n_one = n_one + 1'b1;
        end else begin
          if (n_zero == CNT_W'(k)) zero_v = col_i[j*PSUM_W +: PSUM_W];
          n_zero = n_zero + 1'b1;
        end
      end
    end

    assign one_o[k*PSUM_W +: PSUM_W]  = one_v;
    assign zero_o[k*PSUM_W +: PSUM_W] = zero_v;
  end
endmodule

// File: rtl/psum_recon_merge.sv
module psum_recon_merge
  import psum_recon_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned PSUM_W  = 10,
  localparam int unsigned WORD_W = PSUM_W + GROW_W
) (
  input  logic                      mode_i,
  input  logic [N_WORDS*PSUM_W-1:0] one_i,
  input  logic [N_WORDS*PSUM_W-1:0] zero_i,
  output logic [N_WORDS*WORD_W-1:0] word_o
);
  merge_mode_e mode;
  assign mode = merge_mode_e'(mode_i);

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic signed [WORD_W-1:0] a, b, w;
    assign a = WORD_W'($signed(one_i[k*PSUM_W +: PSUM_W]));
    assign b = WORD_W'($signed(zero_i[k*PSUM_W +: PSUM_W]));
    always_comb begin
      if (mode == MERGE_DIFF) w = a - b;
      else                    w = (a <<< NIB_SHIFT) + b;
    end
    assign word_o[k*WORD_W +: WORD_W] = w;
  end
endmodule

// File: rtl/psum_recon_serial.sv
module psum_recon_serial
  import psum_recon_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned WORD_W  = 15,
  localparam int unsigned RES_W  = WORD_W + GROW_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      ikey_i,
  input  logic [N_WORDS*WORD_W-1:0] word_i,
  output logic [N_WORDS*RES_W-1:0]  result_o,
  output logic                      done_o
);
  logic                      second_q;
  logic                      hi_first_q;
  logic [N_WORDS*WORD_W-1:0] first_q;
  logic [N_WORDS*RES_W-1:0]  res_q, res_d;
  logic                      done_q;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic signed [RES_W-1:0] f, c, hi, lo;
    assign f  = RES_W'($signed(first_q[k*WORD_W +: WORD_W]));
    assign c  = RES_W'($signed(word_i[k*WORD_W +: WORD_W]));
    assign hi = hi_first_q ? f : c;
    assign lo = hi_first_q ? c : f;
    assign res_d[k*RES_W +: RES_W] = (hi <<< NIB_SHIFT) + lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q   <= 1'b0;
      hi_first_q <= 1'b0;
      first_q    <= '0;
      res_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= valid_i & second_q;
      if (valid_i) begin
        second_q <= ~second_q;
        if (!second_q) begin
          first_q    <= word_i;
          hi_first_q <= ikey_i;
        end else begin
          res_q <= res_d;
        end
      end
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/psum_recon.sv
module psum_recon
  import psum_recon_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned PSUM_W  = 10,
  localparam int unsigned COLS   = 2 * N_WORDS,
  localparam int unsigned WORD_W = PSUM_W + GROW_W,
  localparam int unsigned RES_W  = WORD_W + GROW_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      mode_i,
  input  logic [COLS-1:0]           wkey_i,
  input  logic                      ikey_i,
  input  logic [COLS*PSUM_W-1:0]    col_sum_i,
  output logic [N_WORDS*WORD_W-1:0] word_o,
  output logic [N_WORDS*RES_W-1:0]  result_o,
  output logic                      done_o
);
  logic [N_WORDS*PSUM_W-1:0] one_w, zero_w;

  psum_recon_gather #(.N_WORDS(N_WORDS), .PSUM_W(PSUM_W)) u_gather (
    .key_i  (wkey_i),
    .col_i  (col_sum_i),
    .one_o  (one_w),
    .zero_o (zero_w)
  );

  psum_recon_merge #(.N_WORDS(N_WORDS), .PSUM_W(PSUM_W)) u_merge (
    .mode_i (mode_i),
    .one_i  (one_w),
    .zero_i (zero_w),
    .word_o (word_o)
  );

  psum_recon_serial #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_serial (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .ikey_i   (ikey_i),
    .word_i   (word_o),
    .result_o (result_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/psum_recon_chk.sv
module psum_recon_chk #(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned PSUM_W  = 10,
  localparam int unsigned RES_W  = PSUM_W + 10
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [2*N_WORDS-1:0]     wkey_i,
  input logic [N_WORDS*RES_W-1:0] result_o,
  input logic                     done_o
);
  logic ph_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= 1'b0;
    else if (valid_i) ph_q <= ~ph_q;
  end

  AST_KEY_BALANCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($countones(wkey_i) == N_WORDS)); // R1
  AST_DONE_AFTER_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ph_q) |=> done_o); // R6
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ph_q) |=> !done_o); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ph_q) |=> $stable(result_o)); // R7
endmodule

bind psum_recon psum_recon_chk #(.N_WORDS(N_WORDS), .PSUM_W(PSUM_W)) u_chk (.*);

// File: tb/psum_recon_test.sv
module psum_recon_test;
  localparam int N  = 4;
  localparam int P  = 10;
  localparam int C  = 2 * N;
  localparam int WW = P + 5;
  localparam int RW = P + 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0, mode = 1'b0, ikey = 1'b0;
  logic [C-1:0]    wkey = '0;
  logic [C*P-1:0]  col = '0;
  logic [N*WW-1:0] word;
  logic [N*RW-1:0] result;
  logic            done;

  int errors = 0, checks = 0;
  int cols[C];
  int wone[N], wzero[N];
  int exp_w[N];
  int first_w[N];
  int exp_res[N];
  bit ph = 0, kq = 0, exp_done = 0;

  always #2 clk = ~clk;

  psum_recon #(.N_WORDS(N), .PSUM_W(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_i(mode),
    .wkey_i(wkey), .ikey_i(ikey), .col_sum_i(col),
    .word_o(word), .result_o(result), .done_o(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int word_at(int k);
    return $signed(word[k*WW +: WW]);
  endfunction

  function automatic int res_at(int k);
    return $signed(result[k*RW +: RW]);
  endfunction

  // place intended halves into columns per key
  task automatic place(input logic [C-1:0] key);
    int a = 0, b = 0;
    for (int j = 0; j < C; j++) begin
      if (key[j]) begin cols[j] = wone[a]; a++; end
      else        begin cols[j] = wzero[b]; b++; end
    end
  endtask

  task automatic ref_words(input logic [C-1:0] key, input bit m);
    int o[N], z[N];
    int a = 0, b = 0;
    for (int j = 0; j < C; j++) begin
      if (key[j]) begin o[a] = cols[j]; a++; end
      else        begin z[b] = cols[j]; b++; end
    end
    for (int k = 0; k < N; k++) exp_w[k] = m ? o[k] - z[k] : o[k] * 16 + z[k];
  endtask

  // drive one cycle, check comb words, then registered outputs after edge
  task automatic step(input bit v, input bit m, input bit ik,
                      input logic [C-1:0] key, input string tag);
    valid = v; mode = m; ikey = ik; wkey = key;
    for (int j = 0; j < C; j++) col[j*P +: P] = P'(cols[j]);
    #1;
    ref_words(key, m);
    for (int k = 0; k < N; k++) chk({tag, " R4 word"}, word_at(k), exp_w[k]);
    exp_done = 0;
    if (v) begin
      if (!ph) begin
        for (int k = 0; k < N; k++) first_w[k] = exp_w[k];
        kq = ik; ph = 1;
      end else begin
        for (int k = 0; k < N; k++)
          exp_res[k] = kq ? first_w[k] * 16 + exp_w[k] : exp_w[k] * 16 + first_w[k];
        exp_done = 1; ph = 0;
      end
    end
    @(posedge clk); #1;
    chk({tag, " R6/R7 done"}, int'(done), int'(exp_done));
    for (int k = 0; k < N; k++) chk({tag, " R5/R7 result"}, res_at(k), exp_res[k]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) exp_res[k] = 0;
    for (int j = 0; j < C; j++) cols[j] = 0;
    repeat (3) @(posedge clk); #1;
    chk("R8 reset done", int'(done), 0);
    for (int k = 0; k < N; k++) chk("R8 reset result", res_at(k), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 R2: order-keeping key, nibble merge
    wone = '{1, 2, 3, 4}; wzero = '{5, 6, 7, 8};
    place(8'h0F);
    step(0, 0, 0, 8'h0F, "R1 R2 plain");
    for (int k = 0; k < N; k++) chk("R1 R2 intent", word_at(k), wone[k] * 16 + wzero[k]);

    // R1 R3: alternating and irregular keys, differential
    wone = '{-7, 100, 33, -250}; wzero = '{9, -40, 33, 12};
    place(8'hAA);
    step(0, 1, 0, 8'hAA, "R1 R3 alt");
    for (int k = 0; k < N; k++) chk("R3 intent", word_at(k), wone[k] - wzero[k]);
    place(8'h69);
    step(0, 1, 0, 8'h69, "R1 R3 irr");
    step(0, 0, 0, 8'h69, "R1 R2 irr");

    // R5 R6: serial pair, upper first, idle gap
    wone = '{3, -1, 0, 15}; wzero = '{2, 7, -8, 1};
    place(8'h3C);
    step(1, 0, 1, 8'h3C, "R5 first hi");
    step(0, 0, 0, 8'h3C, "R7 gap");
    step(0, 0, 0, 8'h3C, "R7 gap");
    wone = '{-2, 4, 6, -9}; wzero = '{11, 0, -3, 5};
    place(8'hC3);
    step(1, 0, 0, 8'hC3, "R5 second");
    step(0, 0, 1, 8'hC3, "R6 after");

    // R5: upper part second, back-to-back pairs
    place(8'h5A);
    step(1, 1, 0, 8'h5A, "R5 lo first");
    wone = '{1, 1, 1, 1}; wzero = '{0, 2, -2, 9};
    place(8'hA5);
    step(1, 1, 1, 8'hA5, "R5 hi second");
    step(1, 0, 1, 8'hA5, "R5 next pair a");
    step(1, 0, 0, 8'h0F, "R5 next pair b");
    step(0, 0, 0, 8'h0F, "R7 hold");

    // R10: full scale both signs
    wone = '{511, -512, 511, -512}; wzero = '{511, -512, -512, 511};
    place(8'h96);
    step(1, 0, 1, 8'h96, "R10 nib a");
    step(1, 0, 0, 8'h96, "R10 nib b");
    step(1, 1, 1, 8'h96, "R10 diff a");
    step(1, 0, 0, 8'h96, "R10 mix b");

    // R9: mismatched key corrupts, matched restores
    wone = '{10, 20, 30, 40}; wzero = '{-1, -2, -3, -4};
    place(8'h3A);
    step(0, 0, 0, 8'hC5, "R9 wrong");
    begin
      bit diff = 0;
      valid = 0; wkey = 8'hC5; #1;
      for (int k = 0; k < N; k++) if (word_at(k) != wone[k] * 16 + wzero[k]) diff = 1;
      chk("R9 mismatch differs", int'(diff), 1);
    end
    step(0, 0, 0, 8'h3A, "R9 right");
    for (int k = 0; k < N; k++) chk("R9 match", word_at(k), wone[k] * 16 + wzero[k]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule